// File: doc/BRIEF.md
# Chip-Select Bus Cycle Controller

This block runs external memory bus cycles for a single chip-select region on a 32-bit data port. An internal master presents an address, write data, byte enables and a read/write flag with a one-cycle request strobe. The block then drives chip select, output enable, read/write, four byte strobes, the address and the write data from registers. It ends the access after a programmed number of wait states, or, when the wait field holds its all-ones code, when the external active-low transfer acknowledge is sampled low.

A 2-bit interface-type input selects how the byte strobes behave. With type 2'b11 the strobes act as per-lane write enables for 8-bit-wide SRAM or flash parts that have no byte-strobe pins. They stay high on reads and go low only on written lanes, so the read/write pin can be left unconnected. Every other type drives the strobes as lane selects on both reads and writes, and read/write acts as the write qualifier. When a cycle finishes, the master gets a one-cycle done pulse together with the captured read data. At least one idle cycle with chip select high always separates two accesses.

Top module: `cs_bus_ctrl`

## Requirements
- R1: While reset is applied and right after it, cs_n, oe_n, rw_n and all four bs_n bits are high, bus_dout_en and done are low.
- R2: A req strobe sampled while idle starts an access on the next rising edge. cs_n goes low and bus_addr shows req_addr. oe_n is low only for a read (req_we=0), and rw_n is low only for a write.
- R3: When cfg_wait is below 5'h1F, cs_n stays low for exactly cfg_wait+1 clock cycles, and ta_n has no effect on the length.
- R4: When cfg_wait equals 5'h1F, the access stays active until ta_n is sampled low on a rising edge. All strobes deassert on that same edge.
- R5: With cfg_iftype = 2'b11, all bs_n bits stay high during a read. During a write, bs_n[i] is low exactly when req_be[i] is set, where lane i carries data bits 8i+7..8i.
- R6: With any cfg_iftype other than 2'b11, bs_n equals the inverted req_be during both reads and writes.
- R7: For a read, rdata takes the value of bus_din sampled on the terminating edge. A write leaves rdata unchanged.
- R8: done is high for exactly one cycle: the first cycle after the terminating edge, in which cs_n is already high.
- R9: A req strobe given in the done cycle starts the next access on the following edge, which gives exactly one idle cycle between the two accesses.
- R10: A req strobe that arrives while an access is active is ignored. It neither starts an access later nor changes bus_addr.
- R11: During a write access, bus_dout holds req_wdata and bus_dout_en is high. bus_dout_en is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_iftype | input | 2 | Interface type, 2'b11 selects strobes as write enables |
| cfg_wait | input | 5 | Wait states, 5'h1F selects external acknowledge |
| req | input | 1 | One-cycle access request from the master |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Access address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte lane enables |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Captured read data |
| bus_addr | output | 23 | External address |
| bus_dout | output | 32 | External write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 32 | External read data |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| rw_n | output | 1 | High for read, low for write |
| bs_n | output | 4 | Byte strobes, active low |
| ta_n | input | 1 | External transfer acknowledge, active low |

## Verification
The two hardest situations to reach are a request that lands in the middle of an active access and a request that lands exactly in the done cycle. Both depend on timing the master against the block's own termination edge. The stimulus counts active cycles at falling edges and fires the stray request on the second active cycle, or the chained request in the cycle where done is seen. It then checks that the stray request leaves chip select high for several cycles afterwards and that the chained one gets exactly one idle cycle. External-acknowledge lengths are produced the same way, by lowering ta_n after a counted number of active cycles.

// File: rtl/cs_bus_ctrl.sv
module cs_bus_ctrl #(
  parameter int AW  = 23,
  parameter int DW  = 32,
  parameter int WSW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_iftype,
  input  logic [WSW-1:0] cfg_wait,
  input  logic           req,
  input  logic           req_we,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_dout_en,
  input  logic [DW-1:0]  bus_din,
  output logic           cs_n,
  output logic           oe_n,
  output logic           rw_n,
  output logic [DW/8-1:0] bs_n,
  input  logic           ta_n
);
  localparam int NB = DW / 8;
  localparam logic [WSW-1:0] WS_EXT = '1;
  localparam logic [1:0] IF_WREN = 2'b11;

  logic           act;
  logic [WSW-1:0] cnt;

  wire ext   = (cfg_wait == WS_EXT);
  wire fin   = act && (ext ? !ta_n : (cnt == cfg_wait));
  wire start = !act && req;
  wire [NB-1:0] bs_start = (req_we || cfg_iftype != IF_WREN) ? ~req_be : {NB{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act         <= 1'b0;
      cnt         <= '0;
      done        <= 1'b0;
      rdata       <= '0;
      bus_addr    <= '0;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
      cs_n        <= 1'b1;
      oe_n        <= 1'b1;
      rw_n        <= 1'b1;
      bs_n        <= {NB{1'b1}};
    end else begin
      done <= fin;
      if (start) begin
        act         <= 1'b1;
        cnt         <= '0;
        cs_n        <= 1'b0;
        oe_n        <= req_we;
        rw_n        <= !req_we;
        bs_n        <= bs_start;
        bus_addr    <= req_addr;
        bus_dout    <= req_wdata;
        bus_dout_en <= req_we;
      end else if (fin) begin
        act         <= 1'b0;
        cs_n        <= 1'b1;
        oe_n        <= 1'b1;
        rw_n        <= 1'b1;
        bs_n        <= {NB{1'b1}};
        bus_dout_en <= 1'b0;
        if (!oe_n) rdata <= bus_din;
      end else if (act) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !cs_n); // R2
  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !bus_dout_en); // R11
  AST_WREN_READ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_n && cfg_iftype == IF_WREN) |-> bs_n == {NB{1'b1}}); // R5
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cfg_wait == WS_EXT && ta_n) |=> !cs_n); // R4
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cs_n && $past(!cs_n))); // R8
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> done); // R9
endmodule

// File: tb/cs_bus_ctrl_bench.sv
module cs_bus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_iftype = 2'b00;
  logic [4:0]  cfg_wait = 5'd0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        done;
  logic [31:0] rdata;
  logic [22:0] bus_addr;
  logic [31:0] bus_dout;
  logic        bus_dout_en;
  logic [31:0] bus_din = '0;
  logic        cs_n, oe_n, rw_n;
  logic [3:0]  bs_n;
  logic        ta_n = 1'b1;

  int total = 0;
  int bad = 0;
  logic [31:0] last_rd = '0;

  always #5 clk = ~clk;

  cs_bus_ctrl u_cs_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_iftype(cfg_iftype), .cfg_wait(cfg_wait),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .cs_n(cs_n), .oe_n(oe_n), .rw_n(rw_n), .bs_n(bs_n), .ta_n(ta_n)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  be;
    logic [1:0]  ift;
    logic [4:0]  ws;
    logic [4:0]  tack;
    logic [22:0] addr;
    logic [31:0] wdata;
    logic [31:0] din;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'hF, 2'b11, 5'd0,  5'd0, 23'h000100, 32'h0,        32'hA1B2C3D4},
    '{1'b1, 4'hF, 2'b11, 5'd1,  5'd0, 23'h000204, 32'h11223344, 32'h0},
    '{1'b1, 4'h3, 2'b11, 5'd3,  5'd0, 23'h000300, 32'h0000BEEF, 32'h0},
    '{1'b1, 4'h4, 2'b11, 5'd2,  5'd0, 23'h000402, 32'h00550000, 32'h0},
    '{1'b0, 4'hC, 2'b00, 5'd2,  5'd0, 23'h000500, 32'h0,        32'h5A5A0000},
    '{1'b1, 4'h1, 2'b00, 5'd0,  5'd0, 23'h000603, 32'h000000EE, 32'h0},
    '{1'b0, 4'hF, 2'b11, 5'h1F, 5'd4, 23'h7FFFFC, 32'h0,        32'hCAFEF00D},
    '{1'b1, 4'h9, 2'b01, 5'h1F, 5'd1, 23'h000700, 32'h99000077, 32'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic issue(input vec_t v);
    cfg_iftype = v.ift; cfg_wait = v.ws;
    req_we = v.we; req_be = v.be; req_addr = v.addr; req_wdata = v.wdata;
    bus_din = v.din; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish(input vec_t v);
    int n = 0;
    logic [3:0] exp_bs;
    int exp_n;
    exp_bs = (v.we || v.ift != 2'b11) ? ~v.be : 4'hF;
    exp_n  = (v.ws == 5'h1F) ? int'(v.tack) : int'(v.ws) + 1;
    chk(cs_n == 1'b0, "R2 cs_n low after request", 64'(cs_n), 64'd0);
    chk(bus_addr == v.addr, "R2 bus_addr", 64'(bus_addr), 64'(v.addr));
    chk(oe_n == v.we, "R2 oe_n", 64'(oe_n), 64'(v.we));
    chk(rw_n == !v.we, "R2 rw_n", 64'(rw_n), 64'(!v.we));
    if (v.ift == 2'b11) chk(bs_n == exp_bs, "R5 bs_n", 64'(bs_n), 64'(exp_bs));
    else                chk(bs_n == exp_bs, "R6 bs_n", 64'(bs_n), 64'(exp_bs));
    chk(bus_dout_en == v.we && (!v.we || bus_dout == v.wdata), "R11 write data",
        {31'd0, bus_dout_en, bus_dout}, {31'd0, v.we, v.we ? v.wdata : bus_dout});
    while (!cs_n && n < 100) begin
      n++;
      if (v.ws == 5'h1F && n == int'(v.tack)) ta_n = 1'b0;
      @(negedge clk);
    end
    ta_n = 1'b1;
    if (v.ws == 5'h1F) chk(n == exp_n, "R4 ext-ack length", 64'(n), 64'(exp_n));
    else               chk(n == exp_n, "R3 wait length", 64'(n), 64'(exp_n));
    chk(done == 1'b1, "R8 done pulse", 64'(done), 64'd1);
    if (!v.we) last_rd = v.din;
    chk(rdata == last_rd, "R7 rdata", 64'(rdata), 64'(last_rd));
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk({cs_n, oe_n, rw_n, bs_n, bus_dout_en, done} == 9'b111_1111_00, "R1 reset state",
        64'({cs_n, oe_n, rw_n, bs_n, bus_dout_en, done}), 64'h1FC);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !done, "R1 idle after reset", 64'({cs_n, done}), 64'h2);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      finish(VEC[i]);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
    end

    // R3: ta_n held low must not shorten an internally timed access
    v = '{1'b0, 4'hF, 2'b00, 5'd2, 5'd0, 23'h001000, 32'h0, 32'h0BADF00D};
    ta_n = 1'b0;
    issue(v);
    ta_n = 1'b0;
    begin
      int n = 0;
      while (!cs_n && n < 100) begin n++; @(negedge clk); end
      chk(n == 3, "R3 ta_n ignored", 64'(n), 64'd3);
    end
    ta_n = 1'b1;
    last_rd = v.din;
    @(negedge clk);

    // R30 long internal wait
    v = '{1'b1, 4'hF, 2'b11, 5'd30, 5'd0, 23'h002000, 32'hDEADBEEF, 32'h0};
    issue(v);
    finish(v);
    @(negedge clk);

    // R10: stray request during an active access
    v = '{1'b0, 4'hF, 2'b11, 5'd5, 5'd0, 23'h003000, 32'h0, 32'h13572468};
    issue(v);
    @(negedge clk);
    req_addr = 23'h004444; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!cs_n) @(negedge clk);
    last_rd = v.din;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(cs_n == 1'b1 && bus_addr == v.addr, "R10 stray request ignored",
          64'({cs_n, bus_addr}), 64'({1'b1, v.addr}));
    end

    // R9: request in the done cycle gets exactly one idle cycle
    v = '{1'b1, 4'h6, 2'b11, 5'd1, 5'd0, 23'h005000, 32'h00ABCD00, 32'h0};
    issue(v);
    finish(v);
    chk(cs_n == 1'b1, "R9 idle cycle", 64'(cs_n), 64'd1);
    v = '{1'b0, 4'hF, 2'b00, 5'd0, 5'd0, 23'h006000, 32'h0, 32'h24681357};
    issue(v);
    chk(cs_n == 1'b0 && bus_addr == v.addr, "R9 back-to-back start",
        64'({cs_n, bus_addr}), 64'({1'b0, v.addr}));
    finish(v);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule